// File: doc/BRIEF.md
# Transient Recorder Acquisition Controller

This block runs one acquisition of a multichannel sampling recorder. Software sets it up through a small register file with a write strobe and a read strobe. It picks the clock that paces conversions, which is either an internal 1 MHz tick or an external clock pin. It waits for a software trigger or a rising edge on the trigger pin. It then counts a programmed start delay in ticks of the selected clock, and after that issues one conversion strobe every programmed number of ticks. Each strobe comes with the sample-memory write address, which then steps by one.

A run ends on the first of four causes:
- the stop pin at its active level,
- the software stop bit,
- a conversion at the top memory address outside continuous mode, which also flags overflow,
- the programmed number of conversions being reached.

In continuous mode the write address carries over from one trigger to the next and wraps from the top of memory to the bottom. The start-out line reports a run in progress. The start-out line and the stop pin each have a selectable polarity. The selected clock can be forwarded on a clock-out pin so that several units share one source.

Register map (word addresses):
- 0: control.
- 1: start delay in ticks.
- 2: rate, which is the divisor minus one.
- 3: conversion count, where 0 means no limit.
- 4: status, read only.
- 5: current write address, read only.

Read data appears on `rd_data` one cycle after `rd_en`.

Top module: `tr_acq_ctrl`

## Requirements
- R1: The unit acts only while control bit 0 (recorder enable) and control bit 1 (external-mode enable) are both 1. With either bit at 0 a trigger is not accepted. Clearing either bit during a run returns the unit to idle without setting the stopped bit.
- R2: In idle, a trigger is accepted on a write of 1 to control bit 8, or on a rising edge of `ext_trig_i`. Control bit 8 is not stored and reads back 0. Accepting a trigger clears status bit 0 (stopped) and status bit 2 (overflow). A trigger that arrives during the delay or the run is ignored.
- R3: After a trigger is accepted, the unit counts the delay register value in ticks of the selected clock. One cycle later it enters the run.
- R4: In the run, `conv_stb_o` pulses for one cycle on every (rate+1)-th tick of the selected clock. The first pulse comes on the (rate+1)-th tick after the run starts.
- R5: Each strobe presents the current write address on `conv_addr_o`, and the address then steps by one. Outside continuous mode (control bit 2 = 0), an accepted trigger resets the address to 0.
- R6: With a nonzero conversion count N, the run ends after the N-th strobe of that run and sets status bit 0.
- R7: Outside continuous mode, a strobe at the top address (all ones) ends the run, sets status bit 0 and status bit 2, and the address wraps to 0.
- R8: In continuous mode the address is kept across triggers and wraps from the top address to 0 without setting overflow.
- R9: During the delay or the run, the run ends and status bit 0 is set when either of these holds: control bit 7 (software stop) is 1, or `ext_stop_i` is at its active level. The active level is high when control bit 5 is 0 and low when it is 1.
- R10: `start_out_o` is active during the run and follows the state with one cycle of delay. Active is high when control bit 6 is 0 and low when it is 1.
- R11: Control bit 3 selects the clock source: rising edges of `ext_clk_i` when 1, `ref_tick_i` when 0. When control bit 4 is 1, `clk_out_o` shows the selected source one cycle later. When control bit 4 is 0, `clk_out_o` is 0.
- R12: `ext_trig_i`, `ext_stop_i` and `ext_clk_i` each pass through two synchronizing flops before any use.
- R13: After reset, all registers read 0, status is 0, and `conv_stb_o`, `start_out_o` and `clk_out_o` are 0.
- R14: Status bit 1 reads 1 while the unit is in the delay or the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | REG_AW | Register read address |
| rd_data | output | DATA_W | Read data, valid one cycle after rd_en |
| ref_tick_i | input | 1 | Internal 1 MHz reference, one-cycle pulse |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| ext_stop_i | input | 1 | Asynchronous external stop |
| ext_clk_i | input | 1 | Asynchronous external conversion clock |
| clk_out_o | output | 1 | Forwarded conversion clock |
| start_out_o | output | 1 | Run-in-progress line, polarity selectable |
| conv_stb_o | output | 1 | Conversion strobe |
| conv_addr_o | output | ADDR_W | Sample memory write address for the strobe |

## Verification
The results arrive after different numbers of cycles:
- A software trigger written at one edge moves the unit out of idle at the next edge.
- A pin event takes three edges to act: two synchronizer flops, then the edge register or the sequencer.
- Strobes, `clk_out_o` and `rd_data` are registered and appear one cycle after their cause.
- `start_out_o` lags the run state by a further cycle.

The bench keeps a cycle model that is updated at every rising edge from the values present before that edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed reads of status and address, taken after each run has ended, confirm the stop causes, the overflow flag and the continuous-mode wrap.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DELAY = 2'd1, ST_RUN = 2'd2} tr_state_e;

  localparam int A_CTRL   = 0;
  localparam int A_DELAY  = 1;
  localparam int A_RATE   = 2;
  localparam int A_NCONV  = 3;
  localparam int A_STATUS = 4;
  localparam int A_ADDR   = 5;

  localparam int B_REC   = 0;
  localparam int B_EXT   = 1;
  localparam int B_CONT  = 2;
  localparam int B_CSEL  = 3;
  localparam int B_CKEN  = 4;
  localparam int B_SPOL  = 5;
  localparam int B_SOPOL = 6;
  localparam int B_SWSTP = 7;
  localparam int B_TRIG  = 8;
  localparam int CTRL_W  = 8;
endpackage

// File: rtl/tr_sync.sv
module tr_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [1:0] age_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[i];
        s2_q <= s1_q;
      end
    end
    assign sync_o[i] = s2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R12: two flops between pin and use
  p_two_flop_r12: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/tr_rate_div.sv
module tr_rate_div #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tc_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tc_o = run_i && tick_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load_i) cnt_q <= rate_i;
    else if (run_i && tick_i) cnt_q <= (cnt_q == '0) ? rate_i : cnt_q - 1'b1;
  end

  // R4: terminal count reloads the divisor
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (tc_o && !load_i) |=> (cnt_q == $past(rate_i)));
endmodule

// File: rtl/tr_seq.sv
module tr_seq
  import tr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DLY_W  = 20,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              cont_i,
  input  logic              trig_i,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic              tc_i,
  input  logic [DLY_W-1:0]  dly_val_i,
  input  logic [CNT_W-1:0]  nconv_i,
  output logic              load_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              stopped_o,
  output logic              ovf_o
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  tr_state_e         state_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ptr_q, addr_q;
  logic              stb_q, stopped_q, ovf_q;

  assign load_o    = enable_i && (state_q == ST_DELAY) && !stop_i && (dly_q == '0);
  assign run_o     = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_IDLE);
  assign stb_o     = stb_q;
  assign addr_o    = addr_q;
  assign ptr_o     = ptr_q;
  assign stopped_o = stopped_q;
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      dly_q <= '0;
      cnt_q <= '0;
      ptr_q <= '0;
      addr_q <= '0;
      stb_q <= 1'b0;
      stopped_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (!enable_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (trig_i) begin
            state_q <= ST_DELAY;
            dly_q <= dly_val_i;
            cnt_q <= '0;
            stopped_q <= 1'b0;
            ovf_q <= 1'b0;
            if (!cont_i) ptr_q <= '0;
          end
          ST_DELAY: begin
            if (stop_i) begin
              state_q <= ST_IDLE;
              stopped_q <= 1'b1;
            end else if (dly_q == '0) state_q <= ST_RUN;
            else if (tick_i) dly_q <= dly_q - 1'b1;
          end
          ST_RUN: begin
            if (stop_i) begin
              state_q <= ST_IDLE;
              stopped_q <= 1'b1;
            end else if (tc_i) begin
              stb_q <= 1'b1;
              addr_q <= ptr_q;
              ptr_q <= ptr_q + 1'b1;
              cnt_q <= cnt_q + 1'b1;
              if ((nconv_i != '0) && ((cnt_q + 1'b1) == nconv_i)) begin
                state_q <= ST_IDLE;
                stopped_q <= 1'b1;
              end else if ((ptr_q == ADDR_TOP) && !cont_i) begin
                state_q <= ST_IDLE;
                stopped_q <= 1'b1;
                ovf_q <= 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: disabled unit is idle
  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (state_q == ST_IDLE));
  // R2: accepted trigger enters delay with stopped cleared
  p_trig_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (enable_i && (state_q == ST_IDLE) && trig_i) |=> ((state_q == ST_DELAY) && !stopped_q));
  // R9: any stop cause halts delay or run
  p_stop_halts_r9: assert property (@(posedge clk) disable iff (rst)
    (enable_i && (state_q != ST_IDLE) && stop_i) |=> ((state_q == ST_IDLE) && stopped_q));
  // R6: per-run count never reaches the limit while running
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN) && (nconv_i != '0)) |-> (cnt_q < nconv_i));
  // R7, R8: overflow is raised only outside continuous mode
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> !$past(cont_i));
endmodule

// File: rtl/tr_acq_ctrl.sv
module tr_acq_ctrl
  import tr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int RATE_W = 20,
  parameter int DLY_W  = 20,
  parameter int DATA_W = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_tick_i,
  input  logic              ext_trig_i,
  input  logic              ext_stop_i,
  input  logic              ext_clk_i,
  output logic              clk_out_o,
  output logic              start_out_o,
  output logic              conv_stb_o,
  output logic [ADDR_W-1:0] conv_addr_o
);
  localparam int N_PINS = 3;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DLY_W-1:0]  dly_q;
  logic [RATE_W-1:0] rate_q;
  logic [DATA_W-1:0] nconv_q;
  logic              swtrig_q, trig_pv_q, eclk_pv_q, clk_out_q, start_out_q;
  logic [N_PINS-1:0] pin_sync;
  logic              trig_rise, eclk_rise, stop_req, tick, enable;
  logic              load, run, busy, tc, stb, stopped, ovf;
  logic [ADDR_W-1:0] saddr, ptr;

  tr_sync #(.N(N_PINS)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({ext_clk_i, ext_stop_i, ext_trig_i}),
    .sync_o(pin_sync)
  );

  assign trig_rise = pin_sync[0] && !trig_pv_q;
  assign eclk_rise = pin_sync[2] && !eclk_pv_q;
  assign stop_req  = ctrl_q[B_SWSTP] || (pin_sync[1] != ctrl_q[B_SPOL]);
  assign tick      = ctrl_q[B_CSEL] ? eclk_rise : ref_tick_i;
  assign enable    = ctrl_q[B_REC] && ctrl_q[B_EXT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dly_q <= '0;
      rate_q <= '0;
      nconv_q <= '0;
      swtrig_q <= 1'b0;
    end else begin
      swtrig_q <= wr_en && (wr_addr == REG_AW'(A_CTRL)) && wr_data[B_TRIG];
      if (wr_en) begin
        case (wr_addr)
          REG_AW'(A_CTRL):  ctrl_q <= wr_data[CTRL_W-1:0];
          REG_AW'(A_DELAY): dly_q <= wr_data[DLY_W-1:0];
          REG_AW'(A_RATE):  rate_q <= wr_data[RATE_W-1:0];
          REG_AW'(A_NCONV): nconv_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_pv_q <= 1'b0;
      eclk_pv_q <= 1'b0;
      clk_out_q <= 1'b0;
      start_out_q <= 1'b0;
      rd_data <= '0;
    end else begin
      trig_pv_q <= pin_sync[0];
      eclk_pv_q <= pin_sync[2];
      clk_out_q <= ctrl_q[B_CKEN] && (ctrl_q[B_CSEL] ? pin_sync[2] : ref_tick_i);
      start_out_q <= run ^ ctrl_q[B_SOPOL];
      if (rd_en) begin
        case (rd_addr)
          REG_AW'(A_CTRL):   rd_data <= DATA_W'(ctrl_q);
          REG_AW'(A_DELAY):  rd_data <= DATA_W'(dly_q);
          REG_AW'(A_RATE):   rd_data <= DATA_W'(rate_q);
          REG_AW'(A_NCONV):  rd_data <= nconv_q;
          REG_AW'(A_STATUS): rd_data <= DATA_W'({ovf, busy, stopped});
          REG_AW'(A_ADDR):   rd_data <= DATA_W'(ptr);
          default:           rd_data <= '0;
        endcase
      end
    end
  end

  tr_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .load_i(load), .run_i(run), .tick_i(tick),
    .rate_i(rate_q), .tc_o(tc)
  );

  tr_seq #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .CNT_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .enable_i(enable), .cont_i(ctrl_q[B_CONT]),
    .trig_i(trig_rise || swtrig_q), .stop_i(stop_req), .tick_i(tick), .tc_i(tc),
    .dly_val_i(dly_q), .nconv_i(nconv_q), .load_o(load), .run_o(run), .busy_o(busy),
    .stb_o(stb), .addr_o(saddr), .ptr_o(ptr), .stopped_o(stopped), .ovf_o(ovf)
  );

  assign conv_stb_o  = stb;
  assign conv_addr_o = saddr;
  assign clk_out_o   = clk_out_q;
  assign start_out_o = start_out_q;

  // R10: start-out lags the run state by one cycle
  p_start_out_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> (start_out_o != ctrl_q[B_SOPOL]) || $changed(ctrl_q));
endmodule

// File: tb/tr_acq_ctrl_test.sv
module tr_acq_ctrl_test;
  localparam int AW = 6;
  localparam int TP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic ref_tick = 1'b0, ext_trig = 1'b0, ext_stop = 1'b0, ext_clk = 1'b0;
  logic clk_out, start_out, conv_stb;
  logic [AW-1:0] conv_addr;

  int total = 0, bad = 0, cyc = 0, tcnt = 0;
  int stb_seen = 0, last_stb = -1, gap_exp = 0;
  bit gap_on = 1'b0;

  always #10 clk = ~clk;

  tr_acq_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ref_tick_i(ref_tick),
    .ext_trig_i(ext_trig), .ext_stop_i(ext_stop), .ext_clk_i(ext_clk),
    .clk_out_o(clk_out), .start_out_o(start_out), .conv_stb_o(conv_stb),
    .conv_addr_o(conv_addr)
  );

  // behavioural cycle model
  int m_st = 0, m_dly = 0, m_div = 0, m_cnt = 0, m_wp = 0, m_addr = 0;
  bit m_stb = 0, m_stopped = 0, m_ovf = 0, m_sout = 0, m_cko = 0, m_swq = 0;
  bit m_ts1 = 0, m_ts2 = 0, m_tpv = 0, m_ss1 = 0, m_ss2 = 0, m_cs1 = 0, m_cs2 = 0, m_cpv = 0;
  bit c_rec = 0, c_ext = 0, c_cont = 0, c_csel = 0, c_cken = 0, c_spol = 0, c_sopol = 0, c_sws = 0;
  int c_dly = 0, c_rate = 0, c_ncv = 0;
  logic [31:0] m_rdd = '0;

  always @(posedge clk) begin : model
    bit en, trg, erise, sreq, tk, tc, ld;
    int n_st, n_dly, n_div, n_cnt, n_wp, n_addr;
    bit n_stb, n_stopped, n_ovf;
    if (rst) begin
      m_st = 0; m_dly = 0; m_div = 0; m_cnt = 0; m_wp = 0; m_addr = 0;
      m_stb = 0; m_stopped = 0; m_ovf = 0; m_sout = 0; m_cko = 0; m_swq = 0;
      m_ts1 = 0; m_ts2 = 0; m_tpv = 0; m_ss1 = 0; m_ss2 = 0; m_cs1 = 0; m_cs2 = 0; m_cpv = 0;
      c_rec = 0; c_ext = 0; c_cont = 0; c_csel = 0; c_cken = 0; c_spol = 0; c_sopol = 0; c_sws = 0;
      c_dly = 0; c_rate = 0; c_ncv = 0; m_rdd = '0;
    end else begin
      en = c_rec && c_ext;
      trg = (m_ts2 && !m_tpv) || m_swq;
      erise = m_cs2 && !m_cpv;
      sreq = c_sws || (m_ss2 != c_spol);
      tk = c_csel ? erise : ref_tick;
      tc = (m_st == 2) && tk && (m_div == 0);
      ld = en && (m_st == 1) && !sreq && (m_dly == 0);
      n_st = m_st; n_dly = m_dly; n_cnt = m_cnt; n_wp = m_wp; n_addr = m_addr;
      n_stb = 0; n_stopped = m_stopped; n_ovf = m_ovf; n_div = m_div;
      if (ld) n_div = c_rate;
      else if ((m_st == 2) && tk) n_div = (m_div == 0) ? c_rate : m_div - 1;
      if (!en) n_st = 0;
      else if (m_st == 0) begin
        if (trg) begin
          n_st = 1; n_dly = c_dly; n_cnt = 0; n_stopped = 0; n_ovf = 0;
          if (!c_cont) n_wp = 0;
        end
      end else if (sreq) begin
        n_st = 0; n_stopped = 1;
      end else if (m_st == 1) begin
        if (m_dly == 0) n_st = 2;
        else if (tk) n_dly = m_dly - 1;
      end else if (tc) begin
        n_stb = 1; n_addr = m_wp; n_wp = (m_wp + 1) % (1 << AW); n_cnt = m_cnt + 1;
        if ((c_ncv != 0) && (m_cnt + 1 == c_ncv)) begin
          n_st = 0; n_stopped = 1;
        end else if ((m_wp == (1 << AW) - 1) && !c_cont) begin
          n_st = 0; n_stopped = 1; n_ovf = 1;
        end
      end
      m_sout = (m_st == 2) ^ c_sopol;
      m_cko = c_cken && (c_csel ? m_cs2 : ref_tick);
      if (rd_en) begin
        case (rd_addr)
          3'd0: m_rdd = {24'd0, c_sws, c_sopol, c_spol, c_cken, c_csel, c_cont, c_ext, c_rec};
          3'd1: m_rdd = c_dly;
          3'd2: m_rdd = c_rate;
          3'd3: m_rdd = c_ncv;
          3'd4: m_rdd = {29'd0, m_ovf, (m_st != 0), m_stopped};
          3'd5: m_rdd = m_wp;
          default: m_rdd = '0;
        endcase
      end
      m_st = n_st; m_dly = n_dly; m_div = n_div; m_cnt = n_cnt; m_wp = n_wp; m_addr = n_addr;
      m_stb = n_stb; m_stopped = n_stopped; m_ovf = n_ovf;
      m_tpv = m_ts2; m_ts2 = m_ts1; m_ts1 = ext_trig;
      m_ss2 = m_ss1; m_ss1 = ext_stop;
      m_cpv = m_cs2; m_cs2 = m_cs1; m_cs1 = ext_clk;
      m_swq = wr_en && (wr_addr == 3'd0) && wr_data[8];
      if (wr_en) begin
        case (wr_addr)
          3'd0: {c_sws, c_sopol, c_spol, c_cken, c_csel, c_cont, c_ext, c_rec} = wr_data[7:0];
          3'd1: c_dly = int'(wr_data[19:0]);
          3'd2: c_rate = int'(wr_data[19:0]);
          3'd3: c_ncv = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, reference tick, watchdog
  always @(negedge clk) begin
    cyc++;
    tcnt = (tcnt + 1) % TP;
    ref_tick = (tcnt == 0);
    if (!rst) begin
      check(conv_stb === m_stb, "R3/R4 conv_stb_o", int'(conv_stb), int'(m_stb));
      check(conv_addr === m_addr[AW-1:0], "R5 conv_addr_o", int'(conv_addr), m_addr);
      check(start_out === m_sout, "R10 start_out_o", int'(start_out), int'(m_sout));
      check(clk_out === m_cko, "R11 clk_out_o", int'(clk_out), int'(m_cko));
      check(rd_data === m_rdd, "R14 rd_data", int'(rd_data), int'(m_rdd));
      if (conv_stb === 1'b1) begin
        stb_seen++;
        if (gap_on && last_stb >= 0) check(cyc - last_stb == gap_exp, "R4 strobe spacing", cyc - last_stb, gap_exp);
        last_stb = cyc;
      end
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data === 32'(exp), tag, int'(rd_data), exp);
  endtask

  task automatic wait_idle();
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4000 && m_st != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(conv_stb === 1'b0 && start_out === 1'b0 && clk_out === 1'b0, "R13 outputs after reset",
          int'({conv_stb, start_out, clk_out}), 0);
    rd_chk(4, 0, "R13 status after reset");
    rd_chk(2, 0, "R13 rate after reset");

    // A: count-limited run, R3 R4 R6
    wr(1, 3); wr(2, 2); wr(3, 5);
    gap_on = 1'b1; gap_exp = 3 * TP; last_stb = -1; stb_seen = 0;
    wr(0, 32'h103);
    wait_idle();
    gap_on = 1'b0;
    check(stb_seen == 5, "R6 strobes per run", stb_seen, 5);
    rd_chk(4, 1, "R6 stopped after count");
    rd_chk(5, 5, "R5 address after run");
    rd_chk(0, 3, "R2 trigger bit not stored");

    // B: enable gating, R1
    stb_seen = 0;
    wr(0, 32'h101);
    repeat (40) @(negedge clk);
    check(stb_seen == 0, "R1 no strobes when ext bit clear", stb_seen, 0);
    rd_chk(4, 1, "R1 trigger refused when disabled");
    wr(3, 0);
    wr(0, 32'h103);
    repeat (30) @(negedge clk);
    wr(0, 32'h002);
    repeat (3) @(negedge clk);
    rd_chk(4, 0, "R1 disable returns idle, stopped clear");

    // C: pin trigger, retrigger ignored, pin stop, R2 R9 R12
    wr(0, 3); wr(1, 2); wr(2, 1);
    @(negedge clk); ext_trig = 1'b1;
    repeat (4) @(negedge clk); ext_trig = 1'b0;
    repeat (40) @(negedge clk);
    ext_trig = 1'b1; repeat (4) @(negedge clk); ext_trig = 1'b0;
    rd_chk(4, 2, "R14 busy during run");
    repeat (10) @(negedge clk);
    ext_stop = 1'b1;
    wait_idle();
    rd_chk(4, 1, "R9 stop pin ends run");
    ext_stop = 1'b0;
    repeat (4) @(negedge clk);

    // D: polarity, R9 R10
    ext_stop = 1'b1;
    repeat (4) @(negedge clk);
    wr(0, 32'h063);
    wr(0, 32'h163);
    repeat (30) @(negedge clk);
    check(start_out === 1'b0, "R10 active-low start out during run", int'(start_out), 0);
    ext_stop = 1'b0;
    wait_idle();
    rd_chk(4, 1, "R9 low-active stop pin");
    check(start_out === 1'b1, "R10 active-low start out idle", int'(start_out), 1);
    wr(0, 3);

    // E: software stop, R9
    wr(0, 32'h103);
    repeat (30) @(negedge clk);
    wr(0, 32'h083);
    wait_idle();
    rd_chk(4, 1, "R9 software stop");
    wr(0, 3);

    // F: overflow, R7
    wr(1, 0); wr(2, 0); wr(3, 0);
    wr(0, 32'h103);
    wait_idle();
    rd_chk(4, 5, "R7 overflow and stopped");
    rd_chk(5, 0, "R7 address wrapped");

    // G: continuous wrap, R8
    wr(3, 40);
    wr(0, 32'h107);
    wait_idle();
    rd_chk(5, 40, "R8 first continuous run");
    wr(0, 32'h107);
    wait_idle();
    rd_chk(5, 16, "R8 address wrapped across triggers");
    rd_chk(4, 1, "R8 no overflow in continuous mode");

    // H: external clock and forwarding, R11
    wr(1, 1); wr(2, 1); wr(3, 3);
    wr(0, 32'h01B);
    wr(0, 32'h11B);
    for (int i = 0; i < 200 && (i < 6 || m_st != 0); i++) begin
      repeat (3) @(negedge clk);
      ext_clk = ~ext_clk;
    end
    wait_idle();
    rd_chk(5, 3, "R11 conversions on external clock");
    rd_chk(4, 1, "R11 run completed on external clock");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule